// File: doc/BRIEF.md
# Power-of-Two Address Aliasing Tester

This block is a hardware self-test engine for the address wiring between a chip and one of its memories. It is started with the base address and size (in words) of a memory region. It then drives a single-port memory master interface to find out whether any two power-of-two offsets inside that region land on the same physical word. A shorted, stuck-high or stuck-low address line makes two such locations alias. The engine exercises only the address bits inside the region, so the bits above the region keep the values of the base address. The data bus is assumed to work already. The engine touches only log2(size)+1 words: offset 0 and every offset that has exactly one bit set.

A run has three phases. In the fill phase every nonzero power-of-two offset receives the default pattern. In the stuck-high phase the inverse pattern goes to offset 0, every nonzero test offset is read back, and offset 0 is then restored. In the stuck-low/short phase each nonzero test offset in turn receives the inverse pattern. Offset 0 and all other test offsets are then read back, and the marked offset is restored. Every read waits a fixed number of cycles before its data is compared. The first mismatch ends the run. A stuck-high failure reports the offset that was read. A stuck-low or short failure reports the offset that was marked at the time.

The controller has these states. IDLE waits for start. Start moves it to FILL, or to END with a configuration error. FILL writes the pattern at each nonzero offset and then moves to HI_MARK. HI_MARK writes the inverse pattern to offset 0 and moves to HI_RD. HI_RD issues a read and moves to HI_WAIT. HI_WAIT compares the data once the latency has elapsed. On a mismatch it moves to END. After the last offset it moves to HI_RESTORE, and otherwise it returns to HI_RD. HI_RESTORE writes the pattern back to offset 0 and moves to LO_MARK. LO_MARK writes the inverse pattern at the marked offset and moves to LO_RD. LO_RD issues a read and moves to LO_WAIT. LO_WAIT compares the data, with the same three exits as HI_WAIT, leading to END, LO_RESTORE or LO_RD. LO_RESTORE rewrites the marked offset and moves to LO_MARK, or to END with a pass after the last offset. END lasts one cycle and returns to IDLE.

Top module: `addr_alias_tester`

## Requirements
- R1: After reset busy, done, pass, cfg_err and mem_req are 0 and fail_offset is 0.
- R2: A start with size_words not a power of two, or less than 2, accesses no memory. Done goes high in the cycle after start, with cfg_err=1 and pass=0.
- R3: Only offset 0 and each offset 2^k < size_words are accessed. Each access goes to the word whose bits above the region equal base_addr and whose bits inside the region equal the offset.
- R4: The default pattern has alternating bits with a 1 in the MSB (0xAA for 8 bits). The inverse pattern is its bitwise complement (0x55 for 8 bits). Only these two values are ever written.
- R5: A fault-free run performs fill, stuck-high and stuck-low/short phases in that order. With L = log2(size_words), it makes exactly 3L+2 writes and L+L*L reads.
- R6: A mismatch in the stuck-high phase ends the run with pass=0 and fail_offset set to the offset that was read.
- R7: A mismatch in the stuck-low/short phase, whether at offset 0 or at another test offset, ends the run with pass=0 and fail_offset set to the offset that holds the inverse pattern.
- R8: Read data is sampled RD_LAT cycles after the read request, and a read request is never followed by a request in the next cycle.
- R9: The first mismatch stops the run, and no further write is made.
- R10: done is a one-cycle pulse. After a passing run every test offset holds the default pattern again.
- R11: A start while busy is ignored, together with any change of base_addr and size_words.
- R12: pass, cfg_err and fail_offset keep their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when idle |
| base_addr | input | ADDR_W | Region base, aligned to the region size |
| size_words | input | ADDR_W | Region size in words |
| busy | output | 1 | Test running |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last test found no aliasing |
| cfg_err | output | 1 | Last start had an illegal size |
| fail_offset | output | ADDR_W | Offset blamed for the first mismatch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after a read |

## Verification
The bench builds the engine with an 8-bit address, 8-bit data and a read latency of 2. This makes every legal region size from 2 to 128 words reachable, each at an aligned base with upper address bits set. A behavioural memory in the bench can make one address bit stuck high or stuck low, or wire-OR it with its neighbour. Every such fault is swept for every bit inside every region size, plus one fault above the region that must stay invisible. A software walk of the three phases against a second copy of the faulty memory supplies the expected verdict, blamed offset, access counts and final memory image. Illegal sizes and a start pulsed while busy complete the sweep.

// File: rtl/alias_pkg.sv
package alias_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_HI_MARK,
        ST_HI_RD,
        ST_HI_WAIT,
        ST_HI_RESTORE,
        ST_LO_MARK,
        ST_LO_RD,
        ST_LO_WAIT,
        ST_LO_RESTORE,
        ST_END
    } alias_state_e;

    // Alternating bits, MSB of a w-bit word set; w must not exceed 64.
    function automatic logic [63:0] alt_pattern(input int w);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w && ((w - 1 - i) % 2) == 0) begin
                v[i] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/alias_cfg_check.sv
module alias_cfg_check #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] size_words,
    output logic          size_ok,
    output logic [AW-1:0] size_mask
);

    logic [AW-1:0] less_one;

    always_comb begin
        less_one  = size_words - AW'(1);
        size_mask = less_one;
        size_ok   = ((size_words & less_one) == '0) && (size_words > AW'(1));
    end

endmodule

// File: rtl/alias_offset_seq.sv
module alias_offset_seq #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] skip,
    input  logic          skip_en,
    output logic [AW-1:0] nxt,
    output logic          last
);

    logic [AW:0] raw;
    logic [AW:0] step;

    always_comb begin
        if (cur == '0) begin
            raw = (AW+1)'(1);
        end else begin
            raw = {cur, 1'b0};
        end
        if (skip_en && raw == {1'b0, skip}) begin
            step = {raw[AW-1:0], 1'b0};
        end else begin
            step = raw;
        end
        nxt  = step[AW-1:0];
        last = (step & ~{1'b0, mask}) != '0;
    end

endmodule

// File: rtl/alias_rd_timer.sv
module alias_rd_timer #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic ready
);

    localparam int CW = $clog2(RD_LAT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (launch) begin
            cnt_q <= CW'(1);
        end else if (cnt_q == CW'(RD_LAT)) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ready = (cnt_q == CW'(RD_LAT));

    // R8: a new read is only launched once the previous one has been consumed
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (cnt_q == '0));

endmodule

// File: rtl/addr_alias_tester.sv
module addr_alias_tester #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] size_words,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] fail_offset,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    import alias_pkg::*;

    localparam logic [63:0]       PAT_FULL = alt_pattern(DATA_W);
    localparam logic [DATA_W-1:0] PAT      = PAT_FULL[DATA_W-1:0];
    localparam logic [DATA_W-1:0] ANTI     = ~PAT;

    alias_state_e      state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W-1:0] mask_q, mask_d;
    logic [ADDR_W-1:0] chk_q, chk_d;
    logic [ADDR_W-1:0] tgt_q, tgt_d;
    logic [ADDR_W-1:0] fail_q, fail_d;
    logic              pass_q, pass_d;
    logic              cfg_q, cfg_d;

    logic              cfg_ok;
    logic [ADDR_W-1:0] cfg_mask;
    logic [ADDR_W-1:0] chk_nxt, tgt_nxt;
    logic              chk_last, tgt_last;
    logic              rd_launch, rd_ready, rd_bad;
    logic [ADDR_W-1:0] acc_off;

    alias_cfg_check #(.AW(ADDR_W)) u_cfg (
        .size_words (size_words),
        .size_ok    (cfg_ok),
        .size_mask  (cfg_mask)
    );

    alias_offset_seq #(.AW(ADDR_W)) u_chk_seq (
        .cur     (chk_q),
        .mask    (mask_q),
        .skip    (tgt_q),
        .skip_en (state_q == ST_LO_WAIT),
        .nxt     (chk_nxt),
        .last    (chk_last)
    );

    alias_offset_seq #(.AW(ADDR_W)) u_tgt_seq (
        .cur     (tgt_q),
        .mask    (mask_q),
        .skip    ('0),
        .skip_en (1'b0),
        .nxt     (tgt_nxt),
        .last    (tgt_last)
    );

    assign rd_launch = (state_q == ST_HI_RD) || (state_q == ST_LO_RD);
    assign rd_bad    = (mem_rdata != PAT);

    alias_rd_timer #(.RD_LAT(RD_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (rd_launch),
        .ready  (rd_ready)
    );

    // State register and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            chk_q   <= '0;
            tgt_q   <= '0;
            fail_q  <= '0;
            pass_q  <= 1'b0;
            cfg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            mask_q  <= mask_d;
            chk_q   <= chk_d;
            tgt_q   <= tgt_d;
            fail_q  <= fail_d;
            pass_q  <= pass_d;
            cfg_q   <= cfg_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        mask_d  = mask_q;
        chk_d   = chk_q;
        tgt_d   = tgt_q;
        fail_d  = fail_q;
        pass_d  = pass_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pass_d = 1'b0;
                    cfg_d  = 1'b0;
                    fail_d = '0;
                    if (cfg_ok) begin
                        base_d  = base_addr;
                        mask_d  = cfg_mask;
                        chk_d   = ADDR_W'(1);
                        state_d = ST_FILL;
                    end else begin
                        cfg_d   = 1'b1;
                        state_d = ST_END;
                    end
                end
            end
            ST_FILL: begin
                if (chk_last) begin
                    chk_d   = ADDR_W'(1);
                    state_d = ST_HI_MARK;
                end else begin
                    chk_d = chk_nxt;
                end
            end
            ST_HI_MARK: state_d = ST_HI_RD;
            ST_HI_RD:   state_d = ST_HI_WAIT;
            ST_HI_WAIT: begin
                if (rd_ready) begin
                    if (rd_bad) begin
                        fail_d  = chk_q;
                        state_d = ST_END;
                    end else if (chk_last) begin
                        state_d = ST_HI_RESTORE;
                    end else begin
                        chk_d   = chk_nxt;
                        state_d = ST_HI_RD;
                    end
                end
            end
            ST_HI_RESTORE: begin
                tgt_d   = ADDR_W'(1);
                state_d = ST_LO_MARK;
            end
            ST_LO_MARK: begin
                chk_d   = '0;
                state_d = ST_LO_RD;
            end
            ST_LO_RD: state_d = ST_LO_WAIT;
            ST_LO_WAIT: begin
                if (rd_ready) begin
                    if (rd_bad) begin
                        fail_d  = tgt_q;
                        state_d = ST_END;
                    end else if (chk_last) begin
                        state_d = ST_LO_RESTORE;
                    end else begin
                        chk_d   = chk_nxt;
                        state_d = ST_LO_RD;
                    end
                end
            end
            ST_LO_RESTORE: begin
                if (tgt_last) begin
                    pass_d  = 1'b1;
                    state_d = ST_END;
                end else begin
                    tgt_d   = tgt_nxt;
                    state_d = ST_LO_MARK;
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = PAT;
        acc_off   = '0;
        unique case (state_q)
            ST_FILL: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                acc_off = chk_q;
            end
            ST_HI_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ANTI;
            end
            ST_HI_RD, ST_LO_RD: begin
                mem_req = 1'b1;
                acc_off = chk_q;
            end
            ST_HI_RESTORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_LO_MARK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ANTI;
                acc_off   = tgt_q;
            end
            ST_LO_RESTORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                acc_off = tgt_q;
            end
            ST_IDLE, ST_HI_WAIT, ST_LO_WAIT, ST_END: begin
                mem_req = 1'b0;
            end
            default: mem_req = 1'b0;
        endcase
        mem_addr    = (base_q & ~mask_q) | (acc_off & mask_q);
        busy        = (state_q != ST_IDLE) && (state_q != ST_END);
        done        = (state_q == ST_END);
        pass        = pass_q;
        cfg_err     = cfg_q;
        fail_offset = fail_q;
    end

    // R1: no memory traffic while not busy
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2: a configuration error never coincides with a pass verdict
    a_r2_cfg_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pass);

    // R3: every access keeps the upper bits of the latched base
    a_r3_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (((mem_addr ^ base_q) & ~mask_q) == '0));

    // R4: only the pattern or its inverse is written
    a_r4_wdata_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == PAT || mem_wdata == ANTI));

    // R8: a read is followed by a quiet cycle
    a_r8_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    // R9: a failure verdict arrives with no access in flight
    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: region settings are frozen during a run
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(base_q) && $stable(mask_q)));

endmodule

// File: tb/addr_alias_tester_bench.sv
`timescale 1ns/1ps
module addr_alias_tester_bench;

    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int RD_LAT = 2;
    localparam logic [7:0] P = 8'hAA;
    localparam logic [7:0] A = 8'h55;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] size_words = '0;
    logic          busy, done, pass, cfg_err;
    logic [AW-1:0] fail_offset;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    always #2.5 clk = ~clk;

    addr_alias_tester #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(RD_LAT)) u_addr_alias_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .size_words(size_words), .busy(busy), .done(done), .pass(pass),
        .cfg_err(cfg_err), .fail_offset(fail_offset), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    // fault: 0 none, 1 bit stuck high, 2 bit stuck low, 3 bit wire-OR with next bit
    int         fault_kind = 0;
    int         fault_bit = 0;
    logic [7:0] cur_base = '0;
    logic [7:0] cur_size = 8'd2;

    function automatic logic [7:0] phys(input logic [7:0] a);
        logic [7:0] m;
        m = 8'(1) << fault_bit;
        case (fault_kind)
            1: return a | m;
            2: return a & ~m;
            3: begin
                if (a[fault_bit] || a[fault_bit+1]) return a | m | (m << 1);
                return a;
            end
            default: return a;
        endcase
    endfunction

    logic [7:0] mem [0:255];
    logic [7:0] pipe [0:RD_LAT-1];
    logic       load_img = 1'b0;
    int         wr_cnt, rd_cnt, oor_cnt;

    always @(posedge clk) begin
        if (load_img) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
            wr_cnt  <= 0;
            rd_cnt  <= 0;
            oor_cnt <= 0;
        end else if (mem_req) begin
            if (mem_we) begin
                mem[phys(mem_addr)] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                pipe[0] <= mem[phys(mem_addr)];
                rd_cnt  <= rd_cnt + 1;
            end
            if (((mem_addr ^ cur_base) & ~(cur_size - 8'd1)) != 8'd0) oor_cnt <= oor_cnt + 1;
        end
        for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rdata = pipe[RD_LAT-1];

    // Reference walk of the three phases on a second faulty memory
    logic [7:0] ref_mem [0:255];
    int         exp_w, exp_r;
    logic       exp_pass;
    logic [7:0] exp_off;

    task automatic ref_write(input logic [7:0] a, input logic [7:0] d);
        ref_mem[phys(a)] = d;
        exp_w++;
    endtask

    task automatic ref_run(input logic [7:0] base, input int size);
        bit stop;
        logic [7:0] v;
        stop = 0; exp_pass = 1; exp_off = 0; exp_w = 0; exp_r = 0;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h3C;
        for (int o = 1; o < size; o = o * 2) ref_write(base | 8'(o), P);
        ref_write(base, A);
        for (int o = 1; o < size; o = o * 2) begin
            if (!stop) begin
                v = ref_mem[phys(base | 8'(o))]; exp_r++;
                if (v != P) begin stop = 1; exp_pass = 0; exp_off = 8'(o); end
            end
        end
        if (!stop) ref_write(base, P);
        for (int t = 1; t < size; t = t * 2) begin
            if (!stop) begin
                ref_write(base | 8'(t), A);
                v = ref_mem[phys(base)]; exp_r++;
                if (v != P) begin stop = 1; exp_pass = 0; exp_off = 8'(t); end
                for (int o = 1; o < size; o = o * 2) begin
                    if (!stop && o != t) begin
                        v = ref_mem[phys(base | 8'(o))]; exp_r++;
                        if (v != P) begin stop = 1; exp_pass = 0; exp_off = 8'(t); end
                    end
                end
                if (!stop) ref_write(base | 8'(t), P);
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        int cyc;
        cyc = 0;
        seen = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        seen = done;
    endtask

    task automatic load_memory();
        @(negedge clk) load_img = 1'b1;
        @(negedge clk) load_img = 1'b0;
    endtask

    task automatic run_case(input logic [7:0] base, input int size, input int kind,
                            input int fbit, input bit disturb);
        bit seen;
        int diff;
        fault_kind = kind; fault_bit = fbit; cur_base = base; cur_size = 8'(size);
        load_memory();
        ref_run(base, size);
        base_addr = base; size_words = 8'(size); start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (disturb) begin
            repeat (6) @(negedge clk);
            start = 1'b1; size_words = 8'd3; base_addr = ~base;
            @(negedge clk) start = 1'b0;
        end
        wait_done(seen);
        check(seen, "R5 done reached", int'(seen), 1);
        // R6 R7: verdict and blamed offset against the reference walk
        check(pass == exp_pass, exp_pass ? "R5 pass" : "R6/R7 verdict", int'(pass), int'(exp_pass));
        if (!exp_pass) check(fail_offset == exp_off, "R6 R7 fail_offset", int'(fail_offset), int'(exp_off));
        check(cfg_err == 1'b0, "R2 cfg_err on legal size", int'(cfg_err), 0);
        check(wr_cnt == exp_w, "R5 R9 write count", wr_cnt, exp_w);
        check(rd_cnt == exp_r, "R5 R8 read count", rd_cnt, exp_r);
        check(oor_cnt == 0, "R3 accesses outside region", oor_cnt, 0);
        diff = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diff++;
        check(diff == 0, "R4 R9 R10 memory image", diff, 0);
        if (disturb) check(busy == 1'b0, "R11 start during run ignored", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", int'(done), 0);
        check(pass == exp_pass, "R12 verdict held", int'(pass), int'(exp_pass));
    endtask

    task automatic bad_size(input logic [7:0] sz);
        load_memory();
        cur_size = 8'd255;
        size_words = sz; base_addr = 8'h40; start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(done == 1'b1, "R2 done next cycle", int'(done), 1);
        check(cfg_err == 1'b1 && pass == 1'b0, "R2 cfg_err flagged", int'(cfg_err), 1);
        @(negedge clk);
        check(done == 1'b0 && cfg_err == 1'b1, "R12 cfg_err held", int'(cfg_err), 1);
        check(wr_cnt + rd_cnt == 0, "R2 no access", wr_cnt + rd_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && pass == 0 && cfg_err == 0, "R1 reset flags",
              int'({busy, done, pass, cfg_err}), 0);
        check(fail_offset == 0 && mem_req == 0, "R1 reset offset/req", int'(fail_offset), 0);
        rst_n = 1'b1;
        @(negedge clk);

        bad_size(8'd0);
        bad_size(8'd1);
        bad_size(8'd3);
        bad_size(8'd6);
        bad_size(8'd255);

        for (int l = 1; l <= 7; l++) begin
            int sz;
            logic [7:0] b;
            sz = 1 << l;
            b  = 8'hA5 & ~8'(sz - 1);
            run_case(b, sz, 0, 0, 0);
            for (int k = 0; k < l; k++) begin
                run_case(b, sz, 1, k, 0);
                run_case(b, sz, 2, k, 0);
                if (k + 1 < l) run_case(b, sz, 3, k, 0);
            end
        end
        // fault above the region is invisible to the test (R3)
        run_case(8'hA0, 16, 2, 7, 0);
        // start pulsed mid-run with other settings (R11)
        run_case(8'hC0, 32, 0, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule